// File: doc/BRIEF.md
# Receive Activity Edge Detector

This block sits on an idle signalling line and decides when a burst of comparator edges is the start of a real incoming message rather than noise. Each accepted edge is stamped with the value of a free-running time counter. The stamp is stored in a small circular history. When the newest stamp and the oldest one still held are closer together than a fixed window, enough edges have arrived in a short time. The block then pulses a start request to the receive capture logic and masks itself.

While masked, further edges are neither recorded nor acted on. Re-arming unmasks the detector. Any edge that was latched while masked, or that arrives in the re-arm cycle, is discarded. The block also presents the time elapsed since the most recently recorded edge. A protocol controller can use this to judge line quietness.

The history depth, the stamp width and the window are parameters. All time arithmetic is modulo the stamp width, so the counter may wrap freely.

Top module: `rx_act_detector`

## Requirements
- R1: After reset, mon_active is 1, rx_start is 0, every history slot is empty and the stored last stamp is 0, so since_edge equals now_ts.
- R2: An edge strobe sampled while monitoring is processed one cycle later. The stamp taken in the strobe cycle is written to the slot at the write index. The index then advances and wraps from DEPTH-1 back to 0.
- R3: At processing time the span is the new stamp minus the stamp in the slot after the write index, modulo 2^TS_W. When that slot is filled and the span is strictly below WINDOW, rx_start is 1 in the cycle after processing, which is two cycles after the strobe. With the defaults DEPTH=3 and WINDOW=20, three edges whose first-to-last span is below 20 trigger.
- R4: A span equal to or above WINDOW, or a compared slot that is still empty, gives no rx_start and leaves monitoring on.
- R5: rx_start lasts exactly one cycle, and mon_active falls in that same cycle.
- R6: While mon_active is 0, edges are not recorded, since_edge keeps counting from the last recorded stamp, and rx_start stays 0.
- R7: A rearm pulse sets mon_active the next cycle. It discards any edge latched while masked and any edge strobed in the rearm cycle, so neither is ever processed. The history and write index are kept.
- R8: since_edge equals now_ts minus the most recently recorded stamp, modulo 2^TS_W.
- R9: The span is computed modulo 2^TS_W, so edges that straddle a counter wrap still trigger when closely spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| edge_stb | input | 1 | One-cycle strobe per comparator edge |
| now_ts | input | TS_W | Free-running time counter |
| rearm | input | 1 | Re-enable monitoring, dropping any pending edge |
| rx_start | output | 1 | One-cycle request to begin receive capture |
| mon_active | output | 1 | Edge monitoring enabled |
| since_edge | output | TS_W | Time since the last recorded edge |

## Verification
The assertions assume that rearm is a pulse from the receiver or software and not a level held against triggering. They also assume that edge strobes may arrive in any cycle, including while masked. The stimulus drives each strobe and each rearm for exactly one cycle, at the falling clock edge. The bench moves the time counter by single increments, except for one deliberate jump taken right after reset to exercise the wrap. It also places one strobe in the same cycle as a rearm, to exercise the discard rule.

// File: rtl/rxact_pkg.sv
// Package: shared defaults and the circular index helper for the
// receive activity edge detector. Assumes depths of at least two.
package rxact_pkg;
    localparam int unsigned TS_W_DEF   = 16;
    localparam int unsigned DEPTH_DEF  = 3;
    localparam int unsigned WINDOW_DEF = 20;

    // Next slot in a circular history of the given depth.
    function automatic int unsigned ring_next(input int unsigned cur,
                                              input int unsigned depth);
        return (cur == depth - 1) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/rxact_edge_latch.sv
// Module: holds one pending edge and its stamp until the control logic
// consumes it. Assumes clear has priority over a new strobe, and a new
// strobe has priority over consumption.
module rxact_edge_latch #(
    parameter int unsigned TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_stb,
    input  logic [TS_W-1:0] now_ts,
    input  logic            clear,
    input  logic            consume,
    output logic            pend,
    output logic [TS_W-1:0] pend_ts
);
    // Capture or drop the pending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_ts <= '0;
        end else if (clear) begin
            pend    <= 1'b0;
        end else if (edge_stb) begin
            pend    <= 1'b1;
            pend_ts <= now_ts;
        end else if (consume) begin
            pend    <= 1'b0;
        end
    end
endmodule

// File: rtl/rxact_ts_ring.sv
// Module: circular store of edge stamps with a fill flag per slot.
// Assumes the write and read indices are always below DEPTH.
module rxact_ts_ring #(
    parameter int unsigned TS_W  = 16,
    parameter int unsigned DEPTH = 3,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TS_W-1:0]  wr_ts,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TS_W-1:0]  rd_ts,
    output logic             rd_valid
);
    logic [TS_W-1:0] slot_ts  [DEPTH];
    logic            slot_vld [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Store one stamp and mark the slot filled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_ts[s]  <= '0;
                slot_vld[s] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_ts[s]  <= wr_ts;
                slot_vld[s] <= 1'b1;
            end
        end
    end

    // Select the slot being compared against.
    always_comb begin
        rd_ts    = '0;
        rd_valid = 1'b0;
        for (int s = 0; s < DEPTH; s++) begin
            if (rd_idx == IDX_W'(s)) begin
                rd_ts    = slot_ts[s];
                rd_valid = slot_vld[s];
            end
        end
    end
endmodule

// File: rtl/rxact_span_judge.sv
// Module: decides whether the newest stamp lies within the window of the
// oldest held stamp. Assumes modulo arithmetic at the stamp width.
module rxact_span_judge #(
    parameter int unsigned TS_W   = 16,
    parameter int unsigned WINDOW = 20
) (
    input  logic [TS_W-1:0] new_ts,
    input  logic [TS_W-1:0] old_ts,
    input  logic            old_valid,
    output logic            dense
);
    localparam logic [TS_W-1:0] WIN_L = TS_W'(WINDOW);

    logic [TS_W-1:0] span;

    // Wrapping span and strict comparison against the window.
    always_comb begin
        span  = new_ts - old_ts;
        dense = old_valid && (span < WIN_L);
    end
endmodule

// File: rtl/rx_act_detector.sv
// Module: top of the receive activity edge detector. It records edge
// stamps in a circular history, requests receive capture when DEPTH edges
// fall inside WINDOW, then masks itself until rearm. Assumes DEPTH >= 2,
// TS_W <= 32 and a free-running now_ts.
module rx_act_detector
    import rxact_pkg::*;
#(
    parameter int unsigned TS_W   = TS_W_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    parameter int unsigned WINDOW = WINDOW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_stb,
    input  logic [TS_W-1:0] now_ts,
    input  logic            rearm,
    output logic            rx_start,
    output logic            mon_active,
    output logic [TS_W-1:0] since_edge
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             pend;
    logic [TS_W-1:0]  pend_ts;
    logic             process_now;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] nxt_idx;
    logic [TS_W-1:0]  old_ts;
    logic             old_valid;
    logic             dense;
    logic [TS_W-1:0]  last_ts;

    // An edge is handled only while monitoring and outside a rearm cycle.
    assign process_now = pend && mon_active && !rearm;
    assign nxt_idx     = IDX_W'(ring_next(int'(wr_idx), DEPTH));

    rxact_edge_latch #(.TS_W(TS_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_stb (edge_stb),
        .now_ts   (now_ts),
        .clear    (rearm),
        .consume  (process_now),
        .pend     (pend),
        .pend_ts  (pend_ts)
    );

    rxact_ts_ring #(.TS_W(TS_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (process_now),
        .wr_idx   (wr_idx),
        .wr_ts    (pend_ts),
        .rd_idx   (nxt_idx),
        .rd_ts    (old_ts),
        .rd_valid (old_valid)
    );

    rxact_span_judge #(.TS_W(TS_W), .WINDOW(WINDOW)) u_judge (
        .new_ts    (pend_ts),
        .old_ts    (old_ts),
        .old_valid (old_valid),
        .dense     (dense)
    );

    // Advance the write index and keep the latest stamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            last_ts <= '0;
        end else if (process_now) begin
            wr_idx  <= nxt_idx;
            last_ts <= pend_ts;
        end
    end

    // Raise the start pulse and mask or unmask monitoring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_start   <= 1'b0;
            mon_active <= 1'b1;
        end else begin
            rx_start <= process_now && dense;
            if (rearm) begin
                mon_active <= 1'b1;
            end else if (process_now && dense) begin
                mon_active <= 1'b0;
            end
        end
    end

    // Elapsed time since the last recorded edge.
    assign since_edge = now_ts - last_ts;
endmodule

// File: rtl/rx_act_detector_chk.sv
// Module: property checker for rx_act_detector, bound to every instance.
module rx_act_detector_chk #(
    parameter int unsigned TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            edge_stb,
    input logic [TS_W-1:0] now_ts,
    input logic            rearm,
    input logic            rx_start,
    input logic            mon_active,
    input logic [TS_W-1:0] since_edge
);
    // R5: a start request coincides with masking.
    a_r5_start_masks: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> !mon_active);

    // R5: the request lasts one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start);

    // R4: monitoring only drops together with a start request.
    a_r4_fall_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mon_active) |-> rx_start);

    // R6: no start request is raised while masked.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_active |=> !rx_start);

    // R7: rearm unmasks on the next cycle.
    a_r7_rearm_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> mon_active);

    // R7: nothing pending survives a rearm into a start request.
    a_r7_rearm_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !rx_start);

    // R8: with no edge activity the elapsed time tracks the counter.
    a_r8_elapsed_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_stb && !$past(edge_stb) && !rearm && $past(rst_n))
        |=> (since_edge - $past(since_edge)) == (now_ts - $past(now_ts)));
endmodule

bind rx_act_detector rx_act_detector_chk #(.TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_stb   (edge_stb),
    .now_ts     (now_ts),
    .rearm      (rearm),
    .rx_start   (rx_start),
    .mon_active (mon_active),
    .since_edge (since_edge)
);

// File: tb/rx_act_detector_bench.sv
// Bench for rx_act_detector with the defaults DEPTH=3, WINDOW=20, TS_W=16.
module rx_act_detector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_stb = 1'b0;
    logic        rearm = 1'b0;
    logic [15:0] tm = 16'd100;
    logic        rx_start;
    logic        mon_active;
    logic [15:0] since_edge;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    always @(posedge clk) tm <= tm + 16'd1;

    rx_act_detector u_rx_act_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_stb   (edge_stb),
        .now_ts     (tm),
        .rearm      (rearm),
        .rx_start   (rx_start),
        .mon_active (mon_active),
        .since_edge (since_edge)
    );

    typedef struct packed {
        logic [7:0] idle;
        logic       st;
        logic       act;
    } vec_t;

    // Idle cycles before each edge; edge spacing is 2 + idle.
    localparam vec_t VEC [8] = '{
        '{8'd0,  1'b0, 1'b1},  // first edge, compared slot empty (R4)
        '{8'd0,  1'b0, 1'b1},  // second edge, compared slot empty (R4)
        '{8'd30, 1'b0, 1'b1},  // span 34 (R4)
        '{8'd10, 1'b0, 1'b1},  // span 44, index wrapped (R2)
        '{8'd10, 1'b0, 1'b1},  // span 24 (R4)
        '{8'd6,  1'b0, 1'b1},  // span 20 equals window (R4)
        '{8'd9,  1'b1, 1'b0},  // span 19 triggers (R3)
        '{8'd0,  1'b0, 1'b0}   // masked edge ignored (R6)
    };

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one edge at a falling edge and sample two cycles later.
    task automatic pulse_edge(output logic [15:0] t);
        edge_stb = 1'b1;
        t = tm;
        @(negedge clk);
        edge_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [15:0] t_last;
        logic [15:0] t_now;
        do_reset();
        @(negedge clk);
        check("R1 mon_active", 32'(mon_active), 32'd1);
        check("R1 rx_start", 32'(rx_start), 32'd0);
        check("R1 since_edge", 32'(since_edge), 32'(tm));

        for (int i = 0; i < 8; i++) begin
            repeat (VEC[i].idle) @(negedge clk);
            pulse_edge(t_now);
            check($sformatf("R3 rx_start vec %0d", i), 32'(rx_start), 32'(VEC[i].st));
            check($sformatf("R4 mon_active vec %0d", i), 32'(mon_active), 32'(VEC[i].act));
            if (VEC[i].act) check("R8 since_edge", 32'(since_edge), 32'(tm - t_now));
            if (VEC[i].st) begin
                t_last = t_now;
                @(negedge clk);
                check("R5 pulse ends", 32'(rx_start), 32'd0);
                check("R5 still masked", 32'(mon_active), 32'd0);
            end
        end
        check("R6 since_edge from last recorded", 32'(since_edge), 32'(tm - t_last));

        // Rearm with an edge still latched from the masked period.
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        @(negedge clk);
        check("R7 unmasked", 32'(mon_active), 32'd1);
        check("R7 stale edge dropped", 32'(rx_start), 32'd0);
        @(negedge clk);
        check("R7 no late start", 32'(rx_start), 32'd0);
        check("R7 since_edge unchanged base", 32'(since_edge), 32'(tm - t_last));

        // Fresh widely spaced edge after rearm: no trigger, stamp recorded.
        repeat (40) @(negedge clk);
        pulse_edge(t_now);
        check("R4 sparse after rearm", 32'(rx_start), 32'd0);
        check("R2 recorded after rearm", 32'(since_edge), 32'(tm - t_now));

        // Reset while running, then edges straddling the counter wrap.
        do_reset();
        @(negedge clk);
        check("R1 mon_active after reset", 32'(mon_active), 32'd1);
        check("R1 since_edge after reset", 32'(since_edge), 32'(tm));
        tm = 16'hFFFC;
        pulse_edge(t_now);
        check("R9 first", 32'(rx_start), 32'd0);
        pulse_edge(t_now);
        check("R9 second", 32'(rx_start), 32'd0);
        pulse_edge(t_now);
        check("R9 wrap stamp", 32'(t_now), 32'h0000);
        check("R9 wrap trigger", 32'(rx_start), 32'd1);
        check("R5 masked on trigger", 32'(mon_active), 32'd0);
        t_last = t_now;

        // Edge in the same cycle as rearm is discarded.
        edge_stb = 1'b1;
        rearm    = 1'b1;
        @(negedge clk);
        edge_stb = 1'b0;
        rearm    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 same-cycle edge dropped", 32'(rx_start), 32'd0);
        check("R7 active", 32'(mon_active), 32'd1);
        check("R7 no record", 32'(since_edge), 32'(tm - t_last));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule